// File: doc/BRIEF.md
# Receive circular buffer writer

This block writes a received byte stream into a window of a shared, byte-addressed packet RAM. The window is defined by a base address and a span. Capture is armed by a sync-detected pulse, and it starts only if receive ring mode is enabled at that moment. Each stored byte goes to the next location of the window. After the last location, writing returns to the base, so a frame much longer than the window can pass through it. The host drains the window one half at a time.

Two pending flags track the halves. The half flag is set when the location at base plus the split offset is written: the lower half is then ready to drain. The full flag is set when the location at base plus span is written: the upper half is then ready. Each flag stays set until the host acknowledges it, and each has its own output mask.

A 16-bit length, up to 65535 bytes, ends the frame once that many bytes are stored. An abort command ends it earlier. Either way, a one-clock end-of-frame pulse is given and the block waits for the next sync. An overrun flag records that a half was being overwritten while its flag was still pending. The bytes are stored unchanged, with no integrity check and no end-of-payload detection.

Top module: `rxring_writer`

## Requirements
- R1: Out of synchronous reset, `ram_we`, `irq_half`, `irq_full`, `overrun` and `eof` are all 0.
- R2: A byte with `byte_vld` high is stored only after a `sync_hit` pulse was taken while `ring_en` was 1. Any byte that comes before such a sync is dropped, with no RAM write. A sync taken while `ring_en` is 0 arms nothing.
- R3: The first stored byte of a frame goes to `base_addr`. Each later byte goes to the next address, up to `base_addr+span`. The byte after that goes to `base_addr` again. Data is written unchanged. The write appears on the RAM port in the clock after the byte is taken.
- R4: Writing location `base_addr+half_off` sets the half-pending flag, in the same clock as that write. The flag stays set until `ack_half` is pulsed.
- R5: Writing location `base_addr+span` sets the full-pending flag, in the same clock as that write. The flag stays set until `ack_full` is pulsed.
- R6: `irq_half` and `irq_full` show their pending flags only while `irq_en_half` and `irq_en_full` are 1. A flag set while masked is kept, and it appears as soon as its mask is raised.
- R7: Once `max_len` bytes are stored, `eof` is high for exactly one clock, in the same clock as the last write. Further bytes are then dropped until the next sync.
- R8: `abort` during a frame ends it, and `eof` is high in the next clock. A byte offered in the abort clock is not written.
- R9: `overrun` becomes 1 and stays 1 in either of two cases: a byte is written to `base_addr` while the half flag is pending, or a byte is written to `base_addr+half_off+1` while the full flag is pending.
- R10: A sync that starts a frame clears both pending flags and `overrun`. It also restarts the address at `base_addr` and the byte count at zero.
- R11: A `sync_hit` during a frame is ignored, and the address sequence continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ring_en | input | 1 | Receive ring mode enable, sampled when sync arrives |
| base_addr | input | 8 | First RAM location of the window |
| span | input | 8 | Offset of the last location of the window |
| half_off | input | 8 | Offset of the last location of the lower half |
| max_len | input | 16 | Bytes to store before the frame ends |
| sync_hit | input | 1 | Sync-detected pulse |
| byte_vld | input | 1 | Received byte valid |
| byte_dat | input | 8 | Received byte |
| abort | input | 1 | Stop the current frame |
| irq_en_half | input | 1 | Output mask for the half flag |
| irq_en_full | input | 1 | Output mask for the full flag |
| ack_half | input | 1 | Host clears the half flag |
| ack_full | input | 1 | Host clears the full flag |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 8 | RAM write address |
| ram_wdat | output | 8 | RAM write data |
| irq_half | output | 1 | Lower half ready (masked) |
| irq_full | output | 1 | Upper half ready (masked) |
| overrun | output | 1 | A half was overwritten while still pending |
| eof | output | 1 | One-clock end-of-frame pulse |

## Verification
The window wrap is the main target. A design that fails to return to the base writes past `base_addr+span`. A design that restarts one location late or early shows as a wrong address in the scoreboard. Sync is offered before arming, while ring mode is off, and again in the middle of a frame. A block that captures early, or restarts its pointer on a second sync, produces writes the scoreboard does not expect.

Several ends of a frame are covered: the exact length, a length of one, a bare abort, and an abort that arrives together with a byte. These catch an off-by-one in the count, a stretched `eof`, and a byte leaking into RAM in the abort clock. Masking, acknowledgement, overrun on a rewrite of an unacknowledged half, and the clearing at a new sync are each checked at the outputs.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    localparam int RXR_AW    = 8;
    localparam int RXR_DW    = 8;
    localparam int RXR_LW    = 16;
    localparam int RXR_NFLAG = 2;
    localparam int RXR_FHALF = 0;
    localparam int RXR_FFULL = 1;

    typedef logic [RXR_AW-1:0] rxr_addr_t;
    typedef logic [RXR_DW-1:0] rxr_data_t;
    typedef logic [RXR_LW-1:0] rxr_len_t;

    typedef enum logic {
        RXR_IDLE,
        RXR_CAPT
    } rxr_state_e;

    // one RAM write beat
    typedef struct packed {
        logic      we;
        rxr_addr_t addr;
        rxr_data_t data;
    } rxr_wr_t;

    // location events for the byte being accepted this cycle
    typedef struct packed {
        logic at_base;
        logic at_second;
        logic at_half;
        logic at_end;
    } rxr_evt_t;

    function automatic rxr_addr_t rxr_step(input rxr_addr_t p,
                                           input rxr_addr_t base,
                                           input rxr_addr_t span);
        rxr_addr_t last;
        last = rxr_addr_t'(base + span);
        return (p == last) ? base : rxr_addr_t'(p + 1'b1);
    endfunction

endpackage

// File: rtl/rxring_frame_ctrl.sv
module rxring_frame_ctrl
    import rxring_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ring_en,
    input  logic     sync_hit,
    input  logic     byte_vld,
    input  logic     abort,
    input  rxr_len_t max_len,
    output logic     start,
    output logic     accept,
    output logic     eof
);

    rxr_state_e st;
    rxr_len_t   cnt;
    rxr_len_t   cnt_nxt;
    logic       last;

    always_comb begin
        start   = (st == RXR_IDLE) && ring_en && sync_hit;
        accept  = (st == RXR_CAPT) && byte_vld && !abort;
        cnt_nxt = cnt + 1'b1;
        last    = accept && (cnt_nxt == max_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= RXR_IDLE;
            cnt <= '0;
            eof <= 1'b0;
        end else begin
            eof <= 1'b0;
            if (start) begin
                st  <= RXR_CAPT;
                cnt <= '0;
            end else if ((st == RXR_CAPT) && abort) begin
                st  <= RXR_IDLE;
                eof <= 1'b1;
            end else if (accept) begin
                cnt <= cnt_nxt;
                if (last) begin
                    st  <= RXR_IDLE;
                    eof <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rxring_ptr.sv
module rxring_ptr
    import rxring_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      accept,
    input  rxr_addr_t base,
    input  rxr_addr_t span,
    input  rxr_addr_t half_off,
    input  rxr_data_t byte_dat,
    output rxr_wr_t   wr,
    output rxr_evt_t  evt
);

    rxr_addr_t ptr;
    rxr_addr_t loc_half;
    rxr_addr_t loc_second;
    rxr_addr_t loc_end;

    always_comb begin
        loc_half      = rxr_addr_t'(base + half_off);
        loc_second    = rxr_addr_t'(loc_half + 1'b1);
        loc_end       = rxr_addr_t'(base + span);
        evt.at_base   = accept && (ptr == base);
        evt.at_second = accept && (ptr == loc_second);
        evt.at_half   = accept && (ptr == loc_half);
        evt.at_end    = accept && (ptr == loc_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            wr  <= '0;
        end else begin
            wr.we <= accept;
            if (accept) begin
                wr.addr <= ptr;
                wr.data <= byte_dat;
            end
            if (start)
                ptr <= base;
            else if (accept)
                ptr <= rxr_step(ptr, base, span);
        end
    end

endmodule

// File: rtl/rxring_irq.sv
module rxring_irq
    import rxring_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  rxr_evt_t             evt,
    input  logic [RXR_NFLAG-1:0] ack,
    input  logic [RXR_NFLAG-1:0] mask,
    output logic [RXR_NFLAG-1:0] irq,
    output logic                 overrun
);

    logic [RXR_NFLAG-1:0] set_ev;
    logic [RXR_NFLAG-1:0] reuse_ev;
    logic [RXR_NFLAG-1:0] pend;

    always_comb begin
        set_ev[RXR_FHALF]   = evt.at_half;
        set_ev[RXR_FFULL]   = evt.at_end;
        reuse_ev[RXR_FHALF] = evt.at_base;
        reuse_ev[RXR_FFULL] = evt.at_second;
    end

    for (genvar g = 0; g < RXR_NFLAG; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || start)
                pend[g] <= 1'b0;
            else if (set_ev[g])
                pend[g] <= 1'b1;
            else if (ack[g])
                pend[g] <= 1'b0;
        end
        assign irq[g] = pend[g] & mask[g];
    end

    always_ff @(posedge clk) begin
        if (rst || start)
            overrun <= 1'b0;
        else if (|(reuse_ev & pend))
            overrun <= 1'b1;
    end

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
    import rxring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ring_en,
    input  logic [RXR_AW-1:0] base_addr,
    input  logic [RXR_AW-1:0] span,
    input  logic [RXR_AW-1:0] half_off,
    input  logic [RXR_LW-1:0] max_len,
    input  logic              sync_hit,
    input  logic              byte_vld,
    input  logic [RXR_DW-1:0] byte_dat,
    input  logic              abort,
    input  logic              irq_en_half,
    input  logic              irq_en_full,
    input  logic              ack_half,
    input  logic              ack_full,
    output logic              ram_we,
    output logic [RXR_AW-1:0] ram_addr,
    output logic [RXR_DW-1:0] ram_wdat,
    output logic              irq_half,
    output logic              irq_full,
    output logic              overrun,
    output logic              eof
);

    logic                 start;
    logic                 accept;
    rxr_wr_t              wr;
    rxr_evt_t             evt;
    logic [RXR_NFLAG-1:0] irq_v;
    logic [RXR_NFLAG-1:0] ack_v;
    logic [RXR_NFLAG-1:0] mask_v;

    assign ack_v  = {ack_full, ack_half};
    assign mask_v = {irq_en_full, irq_en_half};

    rxring_frame_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ring_en  (ring_en),
        .sync_hit (sync_hit),
        .byte_vld (byte_vld),
        .abort    (abort),
        .max_len  (max_len),
        .start    (start),
        .accept   (accept),
        .eof      (eof)
    );

    rxring_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .accept   (accept),
        .base     (base_addr),
        .span     (span),
        .half_off (half_off),
        .byte_dat (byte_dat),
        .wr       (wr),
        .evt      (evt)
    );

    rxring_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .evt     (evt),
        .ack     (ack_v),
        .mask    (mask_v),
        .irq     (irq_v),
        .overrun (overrun)
    );

    assign ram_we   = wr.we;
    assign ram_addr = wr.addr;
    assign ram_wdat = wr.data;
    assign irq_half = irq_v[RXR_FHALF];
    assign irq_full = irq_v[RXR_FFULL];

endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk
    import rxring_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [RXR_AW-1:0] base_addr,
    input logic [RXR_AW-1:0] span,
    input logic              byte_vld,
    input logic [RXR_DW-1:0] byte_dat,
    input logic              abort,
    input logic              ram_we,
    input logic [RXR_AW-1:0] ram_addr,
    input logic [RXR_DW-1:0] ram_wdat,
    input logic              eof
);

    AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (rst) eof |=> !eof); // R7
    AST_WE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst) ram_we |-> $past(byte_vld)); // R2
    AST_DATA_KEPT: assert property (@(posedge clk) disable iff (rst) ram_we |-> (ram_wdat == $past(byte_dat))); // R3
    AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (rst) abort |=> !ram_we); // R8
    AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst) ram_we |-> ((ram_addr >= $past(base_addr)) && ({1'b0, ram_addr} <= ({1'b0, $past(base_addr)} + {1'b0, $past(span)})))); // R3

endmodule

bind rxring_writer rxring_writer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .base_addr (base_addr),
    .span      (span),
    .byte_vld  (byte_vld),
    .byte_dat  (byte_dat),
    .abort     (abort),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdat  (ram_wdat),
    .eof       (eof)
);

// File: tb/rxring_writer_test.sv
module rxring_writer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ring_en = 1'b0;
    logic [7:0]  base_addr = '0;
    logic [7:0]  span = '0;
    logic [7:0]  half_off = '0;
    logic [15:0] max_len = '0;
    logic        sync_hit = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_dat = '0;
    logic        abort = 1'b0;
    logic        irq_en_half = 1'b1;
    logic        irq_en_full = 1'b1;
    logic        ack_half = 1'b0;
    logic        ack_full = 1'b0;
    logic        ram_we;
    logic [7:0]  ram_addr;
    logic [7:0]  ram_wdat;
    logic        irq_half;
    logic        irq_full;
    logic        overrun;
    logic        eof;

    always #2 clk = ~clk;

    rxring_writer uut (
        .clk(clk), .rst(rst), .ring_en(ring_en), .base_addr(base_addr),
        .span(span), .half_off(half_off), .max_len(max_len),
        .sync_hit(sync_hit), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .abort(abort), .irq_en_half(irq_en_half), .irq_en_full(irq_en_full),
        .ack_half(ack_half), .ack_full(ack_full), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdat(ram_wdat), .irq_half(irq_half),
        .irq_full(irq_full), .overrun(overrun), .eof(eof)
    );

    typedef struct {
        logic [7:0] a;
        logic [7:0] d;
    } exp_t;

    exp_t q[$];
    exp_t mon_e;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && ram_we) begin
            if (q.size() == 0) begin
                chk(1'b0, "R2", "unexpected RAM write", {ram_addr, ram_wdat}, 0);
            end else begin
                mon_e = q.pop_front();
                chk((ram_addr == mon_e.a) && (ram_wdat == mon_e.d), "R3",
                    "write addr/data", {ram_addr, ram_wdat}, {mon_e.a, mon_e.d});
            end
        end
    end

    // driver: offer one byte, return at the negedge where its result shows
    task automatic send_byte(input logic [7:0] d, input bit store, input logic [7:0] a);
        exp_t e;
        @(negedge clk);
        byte_vld = 1'b1;
        byte_dat = d;
        if (store) begin
            e.a = a;
            e.d = d;
            q.push_back(e);
        end
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic do_sync();
        @(negedge clk);
        sync_hit = 1'b1;
        @(negedge clk);
        sync_hit = 1'b0;
    endtask

    task automatic pulse_ack(input bit full);
        @(negedge clk);
        if (full) ack_full = 1'b1; else ack_half = 1'b1;
        @(negedge clk);
        ack_full = 1'b0;
        ack_half = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk({ram_we, irq_half, irq_full, overrun, eof} == 5'b0, "R1", "reset outputs",
            {ram_we, irq_half, irq_full, overrun, eof}, 0);

        base_addr = 8'h40; span = 8'd7; half_off = 8'd3; max_len = 16'd20;
        ring_en = 1'b1;

        // R2: byte before sync is dropped
        send_byte(8'hEE, 1'b0, 8'h00);
        chk(ram_we == 1'b0, "R2", "byte before sync", ram_we, 0);

        do_sync();
        for (int i = 0; i < 20; i++) begin
            d = 8'hA0 ^ 8'(i);
            send_byte(d, 1'b1, 8'(8'h40 + (i % 8)));
            if (i == 3) begin
                chk(irq_half == 1'b1, "R4", "half flag at split", irq_half, 1);
                chk(irq_full == 1'b0, "R5", "full flag early", irq_full, 0);
                pulse_ack(1'b0);
                chk(irq_half == 1'b0, "R4", "half flag after ack", irq_half, 0);
            end
            if (i == 5) do_sync();   // R11: ignored mid-frame
            if (i == 6)
                chk(ram_addr == 8'h46, "R11", "address after mid-frame sync", ram_addr, 8'h46);
            if (i == 7) begin
                chk(irq_full == 1'b1, "R5", "full flag at end", irq_full, 1);
                pulse_ack(1'b1);
                chk(irq_full == 1'b0, "R5", "full flag after ack", irq_full, 0);
            end
            if (i == 8)
                chk(ram_addr == 8'h40, "R3", "wrap to base", ram_addr, 8'h40);
            if (i == 11) pulse_ack(1'b0);
            if (i == 15) pulse_ack(1'b1);
            if (i == 19) begin
                chk(eof == 1'b1, "R7", "eof with last write", eof, 1);
                chk(irq_half == 1'b1, "R4", "half flag on second lap", irq_half, 1);
            end
        end
        @(negedge clk);
        chk(eof == 1'b0, "R7", "eof one clock", eof, 0);
        chk(overrun == 1'b0, "R9", "no overrun with prompt acks", overrun, 0);
        pulse_ack(1'b0);
        send_byte(8'h55, 1'b0, 8'h00);
        chk(ram_we == 1'b0, "R7", "byte after eof dropped", ram_we, 0);

        // R2: sync with ring mode off arms nothing
        ring_en = 1'b0;
        do_sync();
        send_byte(8'h66, 1'b0, 8'h00);
        chk(ram_we == 1'b0, "R2", "sync while disabled", ram_we, 0);
        ring_en = 1'b1;

        // overrun and masking
        base_addr = 8'h80; span = 8'd3; half_off = 8'd1; max_len = 16'd12;
        irq_en_half = 1'b0;
        do_sync();
        for (int i = 0; i < 5; i++) begin
            d = 8'h30 + 8'(i);
            send_byte(d, 1'b1, 8'(8'h80 + (i % 4)));
            if (i == 1) begin
                chk(irq_half == 1'b0, "R6", "masked half flag", irq_half, 0);
                irq_en_half = 1'b1;
                #1;
                chk(irq_half == 1'b1, "R6", "kept flag unmasked", irq_half, 1);
            end
            if (i == 3) begin
                chk(irq_full == 1'b1, "R5", "full flag small window", irq_full, 1);
                chk(overrun == 1'b0, "R9", "no overrun yet", overrun, 0);
            end
            if (i == 4)
                chk(overrun == 1'b1, "R9", "rewrite of pending half", overrun, 1);
        end

        // R8: abort together with a byte
        @(negedge clk);
        abort = 1'b1; byte_vld = 1'b1; byte_dat = 8'h77;
        @(negedge clk);
        abort = 1'b0; byte_vld = 1'b0;
        chk(eof == 1'b1, "R8", "eof after abort", eof, 1);
        chk(ram_we == 1'b0, "R8", "byte in abort clock dropped", ram_we, 0);
        @(negedge clk);
        chk(eof == 1'b0, "R8", "abort eof one clock", eof, 0);
        send_byte(8'h78, 1'b0, 8'h00);
        chk(ram_we == 1'b0, "R8", "byte after abort dropped", ram_we, 0);

        // R10: new frame clears flags and restarts pointer
        do_sync();
        chk({irq_half, irq_full, overrun} == 3'b0, "R10", "flags cleared by sync",
            {irq_half, irq_full, overrun}, 0);
        send_byte(8'h91, 1'b1, 8'h80);
        chk(ram_addr == 8'h80, "R10", "pointer restarted", ram_addr, 8'h80);
        send_byte(8'h92, 1'b1, 8'h81);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(eof == 1'b1, "R8", "bare abort", eof, 1);

        // R7: single-byte frame
        max_len = 16'd1;
        do_sync();
        send_byte(8'h99, 1'b1, 8'h80);
        chk(eof == 1'b1, "R7", "length one frame", eof, 1);
        send_byte(8'h9A, 1'b0, 8'h00);
        chk(ram_we == 1'b0, "R7", "byte after short frame", ram_we, 0);

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R3", "all expected writes seen", q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule